// File: doc/BRIEF.md
# UART Automatic Modem Handshake and Special Character Flag

This block sits between the FIFOs of a UART and its modem pins. It handles the clear-to-send / request-to-send handshake without software. A CTS input that is high stops the transmitter from starting another character. Once synchronised, it raises a halt towards the transmitter, and that halt changes only while the transmitter reports that it is between characters. On the receive side, the block compares the receive FIFO fill level against two programmable thresholds. It drives RTS with hysteresis: RTS goes high at the upper threshold and stays high until the level drains down to the lower threshold.

The block also watches each byte written into the receive FIFO. When special-character detection is on, a byte equal to the programmed match value sets a sticky interrupt flag, and the byte still goes on into the FIFO unchanged. A host read of the interrupt identification register clears the flag.

The feature control byte, the threshold byte, the match byte and the software RTS bit come from registers outside this block.

Top module: `uart_flow_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, tx_halt is 0, spc_flag is 0 and the internal RTS state is 0, so that rts_pin equals sw_rts.
- R2: With feat_ctrl bit 7 set and tx_gap high, a high level on cts_pin makes tx_halt high after the third rising clock edge (two synchroniser flops, then the halt register). A low level clears tx_halt with the same latency.
- R3: While feat_ctrl bit 7 is set and tx_gap is low, tx_halt keeps its value whatever cts_pin does.
- R4: With feat_ctrl bit 7 clear, tx_halt is 0 in the same cycle.
- R5: With feat_ctrl bit 6 set and RTS low, RTS goes high on the next edge once rx_level is at least 4 times thr_ctrl[3:0].
- R6: With feat_ctrl bit 6 set and RTS high, RTS stays high while rx_level is above 4 times thr_ctrl[7:4], and goes low on the next edge once rx_level is at or below that value.
- R7: With feat_ctrl bit 6 clear, rts_pin equals sw_rts and the internal RTS state is cleared.
- R8: With feat_ctrl bit 5 set, a cycle with rx_wr high and rx_char equal to match_char sets spc_flag on the next edge. The byte still appears on rxf_wr/rxf_data in the same cycle, unchanged.
- R9: spc_flag stays set until a cycle with iir_rd high. If a new match and iir_rd occur in the same cycle, the flag remains set.
- R10: With feat_ctrl bit 5 clear, or without rx_wr, a matching byte does not set spc_flag. Bits 4:0 of feat_ctrl have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| feat_ctrl | input | 8 | Bit 7 enables CTS halt, bit 6 enables automatic RTS, bit 5 enables special-character detection |
| thr_ctrl | input | 8 | Bits 3:0 are the RTS halt threshold and bits 7:4 the resume threshold, each in units of 4 entries |
| match_char | input | 8 | Byte compared against received characters |
| sw_rts | input | 1 | Software RTS value, used when automatic RTS is off |
| cts_pin | input | 1 | Asynchronous CTS pin, high means stop |
| tx_gap | input | 1 | High while the transmitter is between characters |
| rx_level | input | 7 | Receive FIFO fill level, 0 to 64 |
| rx_char | input | 8 | Received character |
| rx_wr | input | 1 | Write strobe for rx_char |
| iir_rd | input | 1 | Host read of the interrupt identification register |
| tx_halt | output | 1 | Stops the transmitter from starting a new character |
| rts_pin | output | 1 | RTS pin, high asks the far end to stop |
| rxf_wr | output | 1 | Write strobe forwarded to the receive FIFO |
| rxf_data | output | 8 | Character forwarded to the receive FIFO |
| spc_flag | output | 1 | Sticky special-character interrupt flag |

## Verification
A matching byte can be written in the same cycle as a host read of the interrupt identification register, so the set and the clear of spc_flag fall on one edge. The bench provokes this by first leaving the flag set and then pulsing iir_rd together with a matching rx_wr. It requires the flag to still be high after that edge. It then checks that a lone read clears the flag, so that the set-wins result cannot be confused with a flag that never clears.

// File: rtl/uart_flow_ctrl.sv
module uart_flow_ctrl #(
  parameter int FIFO_DEPTH = 64,
  parameter int CHAR_W     = 8,
  parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        feat_ctrl,
  input  logic [7:0]        thr_ctrl,
  input  logic [CHAR_W-1:0] match_char,
  input  logic              sw_rts,
  input  logic              cts_pin,
  input  logic              tx_gap,
  input  logic [LVL_W-1:0]  rx_level,
  input  logic [CHAR_W-1:0] rx_char,
  input  logic              rx_wr,
  input  logic              iir_rd,
  output logic              tx_halt,
  output logic              rts_pin,
  output logic              rxf_wr,
  output logic [CHAR_W-1:0] rxf_data,
  output logic              spc_flag
);

  localparam int THR_SCALE = FIFO_DEPTH / 16;

  logic en_cts, en_rts, en_spc;
  logic cts_s1, cts_s2, halt_q, rts_q, hit;
  logic [LVL_W-1:0] halt_lvl, resume_lvl;

  assign en_cts = feat_ctrl[7];
  assign en_rts = feat_ctrl[6];
  assign en_spc = feat_ctrl[5];

  assign halt_lvl   = LVL_W'(thr_ctrl[3:0]) * LVL_W'(THR_SCALE);
  assign resume_lvl = LVL_W'(thr_ctrl[7:4]) * LVL_W'(THR_SCALE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cts_s1 <= 1'b0;
      cts_s2 <= 1'b0;
    end else begin
      cts_s1 <= cts_pin;
      cts_s2 <= cts_s1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !en_cts) halt_q <= 1'b0;
    else if (tx_gap)       halt_q <= cts_s2;
  end

  assign tx_halt = halt_q & en_cts;

  always_ff @(posedge clk) begin
    if (!rst_n || !en_rts)                  rts_q <= 1'b0;
    else if (rts_q && rx_level <= resume_lvl) rts_q <= 1'b0;
    else if (!rts_q && rx_level >= halt_lvl)  rts_q <= 1'b1;
  end

  assign rts_pin = en_rts ? rts_q : sw_rts;

  assign rxf_wr   = rx_wr;
  assign rxf_data = rx_char;
  assign hit      = en_spc && rx_wr && (rx_char == match_char);

  always_ff @(posedge clk) begin
    if (!rst_n)      spc_flag <= 1'b0;
    else if (hit)    spc_flag <= 1'b1;
    else if (iir_rd) spc_flag <= 1'b0;
  end

  // R3
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_cts && !tx_gap |=> (!en_cts || tx_halt == $past(tx_halt)));

  // R5
  rts_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_rts && !rts_pin && rx_level >= halt_lvl |=> (!en_rts || rts_pin));

  // R6
  rts_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_rts && rts_pin && rx_level > resume_lvl |=> (!en_rts || rts_pin));

  // R8
  spc_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_spc && rx_wr && rx_char == match_char |=> spc_flag);

  // R9
  spc_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spc_flag && !iir_rd |=> spc_flag);

endmodule

// File: tb/test_uart_flow_ctrl.sv
module test_uart_flow_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] feat_ctrl = 8'h00, thr_ctrl = 8'h00, match_char = 8'h00, rx_char = 8'h00;
  logic sw_rts = 1'b0, cts_pin = 1'b0, tx_gap = 1'b0, rx_wr = 1'b0, iir_rd = 1'b0;
  logic [6:0] rx_level = 7'd0;
  logic tx_halt, rts_pin, rxf_wr, spc_flag;
  logic [7:0] rxf_data;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  uart_flow_ctrl i_uart_flow_ctrl (
    .clk(clk), .rst_n(rst_n), .feat_ctrl(feat_ctrl), .thr_ctrl(thr_ctrl),
    .match_char(match_char), .sw_rts(sw_rts), .cts_pin(cts_pin), .tx_gap(tx_gap),
    .rx_level(rx_level), .rx_char(rx_char), .rx_wr(rx_wr), .iir_rd(iir_rd),
    .tx_halt(tx_halt), .rts_pin(rts_pin), .rxf_wr(rxf_wr), .rxf_data(rxf_data),
    .spc_flag(spc_flag));

  // {thr_ctrl, rx_level, expected rts_pin}
  localparam logic [15:0] RTS_VEC [17] = '{
    {8'h25, 7'd0, 1'b0},  {8'h25, 7'd10, 1'b0}, {8'h25, 7'd19, 1'b0},
    {8'h25, 7'd20, 1'b1}, {8'h25, 7'd30, 1'b1}, {8'h25, 7'd15, 1'b1},
    {8'h25, 7'd9, 1'b1},  {8'h25, 7'd8, 1'b0},  {8'h25, 7'd12, 1'b0},
    {8'h25, 7'd19, 1'b0}, {8'h25, 7'd64, 1'b1}, {8'h25, 7'd8, 1'b0},
    {8'h13, 7'd11, 1'b0}, {8'h13, 7'd12, 1'b1}, {8'h13, 7'd5, 1'b1},
    {8'h13, 7'd4, 1'b0},  {8'h13, 7'd0, 1'b0}};

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #3000000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    sw_rts = 1'b1;
    step(3);
    // R1 during reset
    chk("R1", tx_halt, 1'b0); chk("R1", spc_flag, 1'b0); chk("R1", rts_pin, 1'b1);
    rst_n = 1'b1; sw_rts = 1'b0;
    step(1);
    chk("R1", tx_halt, 1'b0); chk("R1", spc_flag, 1'b0); chk("R1", rts_pin, 1'b0);

    // R5 R6 vector walk
    feat_ctrl = 8'h40;
    foreach (RTS_VEC[i]) begin
      thr_ctrl = RTS_VEC[i][15:8];
      rx_level = RTS_VEC[i][7:1];
      step(1);
      chk(RTS_VEC[i][0] ? "R5" : "R6", rts_pin, RTS_VEC[i][0]);
    end

    // R7 software RTS, then state cleared
    rx_level = 7'd40; thr_ctrl = 8'h25; step(1);
    chk("R5", rts_pin, 1'b1);
    feat_ctrl = 8'h00; sw_rts = 1'b0; #1;
    chk("R7", rts_pin, 1'b0);
    sw_rts = 1'b1; #1; chk("R7", rts_pin, 1'b1);
    sw_rts = 1'b0; rx_level = 7'd15; step(1);
    feat_ctrl = 8'h40; #1;
    chk("R7", rts_pin, 1'b0);
    step(1); chk("R7", rts_pin, 1'b0);
    feat_ctrl = 8'h00; rx_level = 7'd0;

    // R3 no change without gap
    feat_ctrl = 8'h80; tx_gap = 1'b0; cts_pin = 1'b1;
    step(5); chk("R3", tx_halt, 1'b0);
    tx_gap = 1'b1; step(1); chk("R2", tx_halt, 1'b1);
    // R2 latency of release
    cts_pin = 1'b0;
    step(2); chk("R2", tx_halt, 1'b1);
    step(1); chk("R2", tx_halt, 1'b0);
    // R2 latency of assertion
    cts_pin = 1'b1;
    step(2); chk("R2", tx_halt, 1'b0);
    step(1); chk("R2", tx_halt, 1'b1);
    // R3 hold high while in a character
    tx_gap = 1'b0; cts_pin = 1'b0; step(5); chk("R3", tx_halt, 1'b1);
    // R4 disable clears at once
    feat_ctrl = 8'h00; #1; chk("R4", tx_halt, 1'b0);
    tx_gap = 1'b1; cts_pin = 1'b1; step(4); chk("R4", tx_halt, 1'b0);
    cts_pin = 1'b0; step(3);

    // R8 match, forwarded unchanged
    feat_ctrl = 8'h20; match_char = 8'h13;
    rx_char = 8'h13; rx_wr = 1'b1; #1;
    chk("R8", rxf_wr, 1'b1); chk("R8", rxf_data == 8'h13, 1'b1);
    step(1); rx_wr = 1'b0;
    chk("R8", spc_flag, 1'b1);
    step(3); chk("R9", spc_flag, 1'b1);
    iir_rd = 1'b1; step(1); iir_rd = 1'b0;
    chk("R9", spc_flag, 1'b0);
    // non-match
    rx_char = 8'h11; rx_wr = 1'b1; step(1); rx_wr = 1'b0;
    chk("R8", spc_flag, 1'b0);
    // R10 no strobe
    rx_char = 8'h13; step(2); chk("R10", spc_flag, 1'b0);
    // R10 disabled, low bits set
    feat_ctrl = 8'h1F; rx_wr = 1'b1; #1;
    chk("R10", rxf_wr, 1'b1);
    step(1); rx_wr = 1'b0; chk("R10", spc_flag, 1'b0);
    // R9 set wins over read in the same cycle
    feat_ctrl = 8'h20; rx_wr = 1'b1; step(1); rx_wr = 1'b0;
    chk("R9", spc_flag, 1'b1);
    rx_wr = 1'b1; iir_rd = 1'b1; step(1); rx_wr = 1'b0; iir_rd = 1'b0;
    chk("R9", spc_flag, 1'b1);
    iir_rd = 1'b1; step(1); iir_rd = 1'b0;
    chk("R9", spc_flag, 1'b0);

    // R1 reset clears the flag
    rx_wr = 1'b1; step(1); rx_wr = 1'b0;
    rst_n = 1'b0; step(1); chk("R1", spc_flag, 1'b0);
    rst_n = 1'b1; step(1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule